// File: doc/BRIEF.md
# T1 Transmit Frame Timing Generator

This block produces every transmit-side timing mark for a 193-bit T1 frame from one bit-rate clock (1.544 MHz in the target system). A frame is one framing bit followed by 24 eight-bit time slots. Frames group into multiframes of 24 in extended-superframe mode and 12 in superframe mode. From an internal bit counter and frame counter it derives a time-slot clock, a multiframe marker, a signaling-select clock, a signaling-frame flag and a link demand clock. It also composes the serial output: payload bits pass straight through, and the framing-bit slot carries either the link input or a fixed per-mode pattern bit.

Both counters run freely after reset. An upstream framer may pulse a frame-sync input or a multiframe-sync input to realign them. Only the rising edge of each input counts, and a pulse that agrees with the current count changes nothing. The serial stream runs at the fixed line rate and has no back-pressure. The payload and link inputs must be valid during the bit time they occupy, and the output bit for a given bit time is a combinational function of the counter state and those inputs. The link demand clock is high in exactly the frames whose framing bit takes the link input.

Top module: `t1_tx_timing`

## Requirements
- R1: While reset is held and in the first cycle after its release, the block presents the framing bit of frame 1. In that state chan_clk is 0, mf_mark is 1, sig_sel is 1 and sig_frame is 0.
- R2: A frame is 193 bit times. Position 0 is the framing bit. Positions 1..192 are 24 slots of 8 bits. chan_clk is high on slot bits 0..3, low on slot bits 4..7, and low at position 0.
- R3: A multiframe is 24 frames when esf_mode=1 and 12 frames when esf_mode=0. mf_mark is high for the first half of the frames and low for the second half.
- R4: Frames are numbered from 1. sig_sel is high in frames 1-6 and 13-18 in extended mode, so that frames 6 and 18 differ from frames 12 and 24. In superframe mode it is high in frames 1-3 and 7-9.
- R5: sig_frame is 1 exactly in frames whose number is a multiple of 6, and 0 in all other frames.
- R6: link_clk is high in odd-numbered frames in extended mode and in even-numbered frames in superframe mode. In those frames ser_out at position 0 equals link_in.
- R7: At position 0 of the other frames, ser_out carries the framing pattern. In extended mode, frames 4, 8, 12, 16, 20 and 24 carry 0, 0, 1, 0, 1, 1 and frames 2, 6, 10, 14, 18 and 22 carry 0. In superframe mode, frames 1, 3, 5, 7, 9 and 11 carry 1, 0, 1, 0, 1, 0.
- R8: At positions 1..192, ser_out equals pay_in in the same bit time.
- R9: A rising edge on frame_sync marks its own bit time as a framing bit. If the position was not 0, the next bit time is position 1 of the following frame number. If the position was already 0, the edge has no effect.
- R10: A rising edge on mframe_sync marks its own bit time as the framing bit of frame 1, so the next bit time is position 1 of frame 1. It overrides a simultaneous frame_sync edge. When the counters are already at position 0 of frame 1, it has no effect.
- R11: A sync input held high after its rising edge causes no further realignment.
- R12: If a mode change leaves the frame number above the new multiframe length, the count returns to frame 1 at the next frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| esf_mode | input | 1 | 1 = extended superframe (24 frames), 0 = superframe (12 frames) |
| frame_sync | input | 1 | Optional frame alignment pulse, rising edge active |
| mframe_sync | input | 1 | Optional multiframe alignment pulse, rising edge active |
| pay_in | input | 1 | Serial payload bit for the current bit time |
| link_in | input | 1 | Link bit, taken at the framing bit of link frames |
| chan_clk | output | 1 | Time-slot clock, 50% within each slot |
| mf_mark | output | 1 | Multiframe marker, high for the first half |
| sig_sel | output | 1 | Signaling-select clock |
| sig_frame | output | 1 | High during signaling frames |
| link_clk | output | 1 | Link demand clock, high in link frames |
| ser_out | output | 1 | Composed serial stream |

## Verification
The timing outputs are checked in every bit time of two free-running extended multiframes and three superframe multiframes, with payload and link bits from a shift register so that passthrough, link insertion and pattern insertion can be told apart. Frame-sync pulses are placed at many misaligned offsets, at position 0 and at the last bit, which separates a real reload from a no-op. Multiframe-sync pulses are applied misaligned, aligned, and together with frame-sync, which shows precedence. Long high levels on each sync input show that only edges act. A switch to superframe mode while the count is at frame 16 exercises the wrap back to frame 1.

// File: rtl/t1tx_pkg.sv
`timescale 1ns/1ps
package t1tx_pkg;

  localparam int unsigned DEF_SLOT_BITS  = 8;
  localparam int unsigned DEF_SLOTS      = 24;
  localparam int unsigned DEF_ESF_FRAMES = 24;
  localparam int unsigned DEF_SF_FRAMES  = 12;
  localparam int unsigned DEF_SIG_PERIOD = 6;

  // Extended mode: pattern bit for the frame 4*(grp+1)
  function automatic logic esf_pattern_bit(input logic [2:0] grp);
    logic [5:0] seq;
    seq = 6'b110100;
    if (grp < 3'd6) return seq[grp];
    return 1'b0;
  endfunction

  // Superframe mode: odd frames alternate 1,0 starting at frame 1
  function automatic logic sf_pattern_bit(input logic pair_lsb);
    return ~pair_lsb;
  endfunction

endpackage

// File: rtl/t1tx_bit_ctr.sv
`timescale 1ns/1ps
module t1tx_bit_ctr #(
  parameter int unsigned SLOT_BITS = 8,
  parameter int unsigned SLOTS = 24,
  localparam int unsigned FRAME_BITS = 1 + SLOT_BITS * SLOTS,
  localparam int unsigned BPW = $clog2(FRAME_BITS),
  localparam int unsigned SBW = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           realign,
  output logic [BPW-1:0] bit_pos,
  output logic [SBW-1:0] slot_bit,
  output logic           frame_end
);

  assign frame_end = (bit_pos == BPW'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_pos  <= '0;
      slot_bit <= '0;
    end else if (realign) begin
      bit_pos  <= BPW'(1);
      slot_bit <= '0;
    end else if (frame_end) begin
      bit_pos  <= '0;
      slot_bit <= '0;
    end else begin
      bit_pos <= bit_pos + BPW'(1);
      if (bit_pos == '0 || slot_bit == SBW'(SLOT_BITS - 1))
        slot_bit <= '0;
      else
        slot_bit <= slot_bit + SBW'(1);
    end
  end

endmodule

// File: rtl/t1tx_frame_ctr.sv
`timescale 1ns/1ps
module t1tx_frame_ctr #(
  parameter int unsigned ESF_FRAMES = 24,
  parameter int unsigned SF_FRAMES = 12,
  localparam int unsigned FIW = $clog2(ESF_FRAMES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           esf_mode,
  input  logic           advance,
  input  logic           to_first,
  output logic [FIW-1:0] frame_idx
);

  logic [FIW-1:0] last_idx;
  logic           at_wrap;

  assign last_idx = esf_mode ? FIW'(ESF_FRAMES - 1) : FIW'(SF_FRAMES - 1);
  assign at_wrap  = (frame_idx >= last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n)
      frame_idx <= '0;
    else if (to_first)
      frame_idx <= '0;
    else if (advance)
      frame_idx <= at_wrap ? '0 : frame_idx + FIW'(1);
  end

endmodule

// File: rtl/t1tx_decode.sv
`timescale 1ns/1ps
module t1tx_decode
  import t1tx_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 8,
  parameter int unsigned SLOTS = 24,
  parameter int unsigned ESF_FRAMES = 24,
  parameter int unsigned SF_FRAMES = 12,
  parameter int unsigned SIG_PERIOD = 6,
  localparam int unsigned FRAME_BITS = 1 + SLOT_BITS * SLOTS,
  localparam int unsigned BPW = $clog2(FRAME_BITS),
  localparam int unsigned SBW = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1,
  localparam int unsigned FIW = $clog2(ESF_FRAMES),
  localparam int unsigned SIG_COUNT = ESF_FRAMES / SIG_PERIOD
) (
  input  logic           esf_mode,
  input  logic [BPW-1:0] bit_pos,
  input  logic [SBW-1:0] slot_bit,
  input  logic [FIW-1:0] frame_idx,
  input  logic           pay_in,
  input  logic           link_in,
  output logic           chan_clk,
  output logic           mf_mark,
  output logic           sig_sel,
  output logic           sig_frame,
  output logic           link_clk,
  output logic           ser_out
);

  logic [FIW:0] frames_now, half_len, quarter_len, idx_ext;
  logic         is_fbit, pattern_bit, fbit_val;
  logic [FIW-1:0] grp_idx;

  assign frames_now  = esf_mode ? (FIW+1)'(ESF_FRAMES) : (FIW+1)'(SF_FRAMES);
  assign half_len    = frames_now >> 1;
  assign quarter_len = frames_now >> 2;
  assign idx_ext     = {1'b0, frame_idx};
  assign is_fbit     = (bit_pos == '0);

  assign chan_clk = !is_fbit && (slot_bit < SBW'(SLOT_BITS / 2));
  assign mf_mark  = (idx_ext < half_len);
  assign sig_sel  = (idx_ext < quarter_len) ||
                    ((idx_ext >= (quarter_len << 1)) &&
                     (idx_ext < (quarter_len << 1) + quarter_len));

  always_comb begin
    sig_frame = 1'b0;
    for (int k = 1; k <= int'(SIG_COUNT); k++)
      if (frame_idx == FIW'(k * int'(SIG_PERIOD) - 1)) sig_frame = 1'b1;
  end

  assign link_clk = esf_mode ? ~frame_idx[0] : frame_idx[0];
  assign grp_idx  = frame_idx >> 2;

  always_comb begin
    if (esf_mode)
      pattern_bit = (frame_idx[1:0] == 2'b11) ? esf_pattern_bit(3'(grp_idx)) : 1'b0;
    else
      pattern_bit = sf_pattern_bit(frame_idx[1]);
  end

  assign fbit_val = link_clk ? link_in : pattern_bit;
  assign ser_out  = is_fbit ? fbit_val : pay_in;

endmodule

// File: rtl/t1_tx_timing.sv
`timescale 1ns/1ps
module t1_tx_timing
  import t1tx_pkg::*;
#(
  parameter int unsigned SLOT_BITS = DEF_SLOT_BITS,
  parameter int unsigned SLOTS = DEF_SLOTS,
  parameter int unsigned ESF_FRAMES = DEF_ESF_FRAMES,
  parameter int unsigned SF_FRAMES = DEF_SF_FRAMES,
  parameter int unsigned SIG_PERIOD = DEF_SIG_PERIOD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic esf_mode,
  input  logic frame_sync,
  input  logic mframe_sync,
  input  logic pay_in,
  input  logic link_in,
  output logic chan_clk,
  output logic mf_mark,
  output logic sig_sel,
  output logic sig_frame,
  output logic link_clk,
  output logic ser_out
);

  localparam int unsigned FRAME_BITS = 1 + SLOT_BITS * SLOTS;
  localparam int unsigned BPW = $clog2(FRAME_BITS);
  localparam int unsigned SBW = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
  localparam int unsigned FIW = $clog2(ESF_FRAMES);

  logic           fs_q, mf_q;
  logic           fs_rise, mf_rise, fs_hit, mf_hit;
  logic [BPW-1:0] bit_pos;
  logic [SBW-1:0] slot_bit;
  logic [FIW-1:0] frame_idx;
  logic           frame_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q <= 1'b0;
      mf_q <= 1'b0;
    end else begin
      fs_q <= frame_sync;
      mf_q <= mframe_sync;
    end
  end

  assign fs_rise = frame_sync & ~fs_q;
  assign mf_rise = mframe_sync & ~mf_q;
  assign mf_hit  = mf_rise & ~((bit_pos == '0) & (frame_idx == '0));
  assign fs_hit  = fs_rise & (bit_pos != '0) & ~mf_hit;

  t1tx_bit_ctr #(.SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS)) u_bit (
    .clk(clk), .rst_n(rst_n), .realign(fs_hit | mf_hit),
    .bit_pos(bit_pos), .slot_bit(slot_bit), .frame_end(frame_end)
  );

  t1tx_frame_ctr #(.ESF_FRAMES(ESF_FRAMES), .SF_FRAMES(SF_FRAMES)) u_frame (
    .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode),
    .advance(fs_hit | frame_end), .to_first(mf_hit), .frame_idx(frame_idx)
  );

  t1tx_decode #(
    .SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS), .ESF_FRAMES(ESF_FRAMES),
    .SF_FRAMES(SF_FRAMES), .SIG_PERIOD(SIG_PERIOD)
  ) u_dec (
    .esf_mode(esf_mode), .bit_pos(bit_pos), .slot_bit(slot_bit),
    .frame_idx(frame_idx), .pay_in(pay_in), .link_in(link_in),
    .chan_clk(chan_clk), .mf_mark(mf_mark), .sig_sel(sig_sel),
    .sig_frame(sig_frame), .link_clk(link_clk), .ser_out(ser_out)
  );

endmodule

// File: rtl/t1_tx_timing_chk.sv
`timescale 1ns/1ps
module t1_tx_timing_chk #(
  parameter int unsigned BPW = 8,
  parameter int unsigned FIW = 5,
  parameter int unsigned FRAME_BITS = 193
) (
  input logic           clk,
  input logic           rst_n,
  input logic           esf_mode,
  input logic           fs_rise,
  input logic           mf_rise,
  input logic [BPW-1:0] bit_pos,
  input logic [FIW-1:0] frame_idx,
  input logic           chan_clk,
  input logic           sig_frame,
  input logic           link_clk
);

  // R2: slot clock is quiet during the framing bit
  a_r2_fbit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_pos == '0) |-> !chan_clk);

  // R2: a free-running frame ends after the last bit
  a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_pos == BPW'(FRAME_BITS - 1) && !fs_rise && !mf_rise) |=> (bit_pos == '0));

  // R9: a frame-sync edge off position 0 reloads to position 1
  a_r9_frame_realign: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_rise && !mf_rise && bit_pos != '0) |=> (bit_pos == BPW'(1)));

  // R10: a multiframe-sync edge lands on position 1 of frame 1
  a_r10_mframe_realign: assert property (@(posedge clk) disable iff (!rst_n)
    mf_rise |=> (bit_pos == BPW'(1) && frame_idx == '0));

  // R5, R6: extended-mode signaling frames are never link frames
  a_r5_sig_not_link: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_frame && esf_mode) |-> !link_clk);

endmodule

bind t1_tx_timing t1_tx_timing_chk #(
  .BPW(BPW), .FIW(FIW), .FRAME_BITS(FRAME_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .fs_rise(fs_rise),
  .mf_rise(mf_rise), .bit_pos(bit_pos), .frame_idx(frame_idx),
  .chan_clk(chan_clk), .sig_frame(sig_frame), .link_clk(link_clk)
);

// File: tb/test_t1_tx_timing.sv
`timescale 1ns/1ps
module test_t1_tx_timing;

  logic clk = 1'b0;
  logic rst_n, esf_mode, frame_sync, mframe_sync, pay_in, link_in;
  logic chan_clk, mf_mark, sig_sel, sig_frame, link_clk, ser_out;

  int n_chk = 0;
  int n_fail = 0;
  int b = 0;
  int f = 0;
  bit fs_prev = 0;
  bit mf_prev = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  t1_tx_timing i_t1_tx_timing (
    .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .frame_sync(frame_sync),
    .mframe_sync(mframe_sync), .pay_in(pay_in), .link_in(link_in),
    .chan_clk(chan_clk), .mf_mark(mf_mark), .sig_sel(sig_sel),
    .sig_frame(sig_frame), .link_clk(link_clk), .ser_out(ser_out)
  );

  task automatic chk(string rq, string name, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b (bit %0d frame %0d)",
               rq, name, act, exp, b, f + 1);
    end
  endtask

  function automatic string tag(string ph, string rq);
    return (ph == "") ? rq : {ph, "+", rq};
  endfunction

  function automatic bit esf_pat(int grp);
    case (grp)
      2: return 1'b1;
      4: return 1'b1;
      5: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic compare(string ph);
    int n = esf_mode ? 24 : 12;
    bit lf = esf_mode ? (f % 2 == 0) : (f % 2 == 1);
    bit pat;
    bit exp_ser;
    if (esf_mode) pat = (f % 4 == 3) ? esf_pat(f / 4) : 1'b0;
    else          pat = ((f / 2) % 2 == 0);
    exp_ser = (b == 0) ? (lf ? link_in : pat) : pay_in;
    chk(tag(ph, "R2"), "chan_clk", chan_clk, (b != 0) && (((b - 1) % 8) < 4));
    chk(tag(ph, "R3"), "mf_mark", mf_mark, f < n / 2);
    chk(tag(ph, "R4"), "sig_sel", sig_sel, (f % (n / 2)) < (n / 4));
    chk(tag(ph, "R5"), "sig_frame", sig_frame, ((f + 1) % 6) == 0);
    chk(tag(ph, "R6"), "link_clk", link_clk, lf);
    chk(tag(ph, (b != 0) ? "R8" : (lf ? "R6" : "R7")), "ser_out", ser_out, exp_ser);
  endtask

  function automatic int wrapf(int fr);
    int n = esf_mode ? 24 : 12;
    return (fr >= n - 1) ? 0 : fr + 1;
  endfunction

  // Called at a falling edge; leaves at the next falling edge
  task automatic step(string ph, bit fsv, bit mfv);
    bit fs_r, mf_r, mf_hit, fs_hit;
    frame_sync  = fsv;
    mframe_sync = mfv;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    pay_in  = lfsr[0];
    link_in = lfsr[7];
    #1;
    compare(ph);
    fs_r = fsv && !fs_prev;
    mf_r = mfv && !mf_prev;
    mf_hit = mf_r && !(b == 0 && f == 0);
    fs_hit = fs_r && (b != 0) && !mf_hit;
    if (mf_hit) begin b = 1; f = 0; end
    else if (fs_hit) begin b = 1; f = wrapf(f); end
    else if (b == 192) begin b = 0; f = wrapf(f); end
    else b++;
    fs_prev = fsv;
    mf_prev = mfv;
    @(negedge clk);
  endtask

  task automatic run(string ph, int n);
    for (int i = 0; i < n; i++) step(ph, 1'b0, 1'b0);
  endtask

  task automatic run_to(string ph, int tb, int tf);
    for (int i = 0; i < 24 * 193 && !(b == tb && (tf < 0 || f == tf)); i++)
      step(ph, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; esf_mode = 1'b1; frame_sync = 1'b0; mframe_sync = 1'b0;
    pay_in = 1'b0; link_in = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "chan_clk", chan_clk, 1'b0);
    chk("R1", "mf_mark", mf_mark, 1'b1);
    chk("R1", "sig_sel", sig_sel, 1'b1);
    chk("R1", "sig_frame", sig_frame, 1'b0);
    chk("R1", "link_clk", link_clk, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    step("R1", 1'b0, 1'b0);
    run("", 2 * 24 * 193 - 1);

    // Mode change above the superframe length (R12)
    run("", 15 * 193 + 50);
    esf_mode = 1'b0;
    run("R12", 2 * 193);
    run("", 3 * 12 * 193);

    // Frame-sync realignment (R9)
    for (int i = 0; i < 6; i++) begin
      run("R9", 131 + i * 71);
      step("R9", 1'b1, 1'b0);
      run("R9", 300);
    end
    run_to("R9", 0, -1);
    step("R9", 1'b1, 1'b0);
    run("R9", 300);
    run_to("R9", 192, -1);
    step("R9", 1'b1, 1'b0);
    run("R9", 300);

    // Multiframe-sync realignment (R10)
    for (int i = 0; i < 5; i++) begin
      run("R10", 97 + i * 953);
      step("R10", 1'b0, 1'b1);
      run("R10", 400);
    end
    run_to("R10", 0, 0);
    step("R10", 1'b0, 1'b1);
    run("R10", 400);
    run("R10", 77);
    step("R10", 1'b1, 1'b1);
    run("R10", 400);

    // Held levels act only on the edge (R11)
    step("R11", 1'b1, 1'b0);
    for (int i = 0; i < 600; i++) step("R11", 1'b1, 1'b0);
    run("R11", 200);
    step("R11", 1'b0, 1'b1);
    for (int i = 0; i < 600; i++) step("R11", 1'b0, 1'b1);
    run("R11", 200);

    // Back to extended mode with pulses
    esf_mode = 1'b1;
    run("R12", 400);
    run("", 24 * 193);
    run("R9", 500);
    step("R9", 1'b1, 1'b0);
    run("R9", 400);
    run("R10", 3000);
    step("R10", 1'b0, 1'b1);
    run("R10", 24 * 193);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule